// File: doc/BRIEF.md
# Cascadable Bitstream Memory Streamer

This block is the read side of a boot memory that feeds a stored configuration image into a programmable logic device. The image sits in an on-chip byte array whose contents come from a parameter. An address counter steps through the image on rising clock edges while the part is selected and out of reset. Each output lane has its own drive-enable bit, which a pad ring can map onto real tri-state pins.

Two static straps set how the part is used. One strap sets which level of the shared reset/output-enable pin means reset. The other strap picks the output mode. In serial mode, lane 0 alone carries the image, one bit per step, with the most significant bit of each byte first. In parallel mode, all eight lanes carry one byte per step. A stall input freezes the counter.

When the counter passes the last valid address, the part stops driving its lanes and pulls its cascade output low. That output drives the chip-enable of the next part, so a chain of parts delivers one continuous image.

Top module: `cfg_stream_rom`

## Requirements
- R1: While the part is selected (`ce_n` low), out of reset, not past terminal count and `busy` low, every rising clock edge advances the address counter by one.
- R2: `data_oe` is nonzero only while the part is selected, out of reset and not past terminal count. Otherwise every `data_oe` bit is 0.
- R3: With `pol_rst_high` = 1, `rst_oe` high means reset and low means output enabled. With `pol_rst_high` = 0, the meanings are swapped, so low means reset.
- R4: A clock edge taken while reset is active clears the counter, so the stream restarts from byte 0, bit 7.
- R5: A clock edge taken while `ce_n` is high clears the counter. Raising `ce_n` releases all lanes in the same cycle.
- R6: `ceo_n` is low only while the part is selected, out of reset and past terminal count. It returns high in the same cycle that reset is asserted or `ce_n` rises.
- R7: While `busy` is high, clock edges leave the counter unchanged and the output value is held.
- R8: With `par_mode` = 0, only lane 0 is driven. `data_oe[7:1]` stays 0, and byte k (bits `IMAGE[8k+7:8k]`) is sent from bit 7 down to bit 0.
- R9: With `par_mode` = 1, all eight lanes are driven (`data_oe` = 8'hFF), and step k presents byte k of `IMAGE` on `data_o`.
- R10: The terminal count is `TC_BYTE` in parallel mode and `TC_BYTE*8+7` in serial mode. Once past it, the counter stops and never wraps, and the lanes stay released until the next clear.
- R11: When two parts are chained through `ceo_n` to `ce_n`, the second part drives its own byte 0 in the cycle after the first part's last step. The first part's lanes are released from that cycle on, so the merged stream has no gap and no overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; rising edges step the counter |
| ce_n | input | 1 | Active-low chip select |
| rst_oe | input | 1 | Shared reset / output-enable pin, polarity set by `pol_rst_high` |
| pol_rst_high | input | 1 | Strap: 1 = high on `rst_oe` is reset, 0 = low is reset |
| par_mode | input | 1 | Strap: 0 = serial on lane 0, 1 = byte-wide |
| busy | input | 1 | Stall: high freezes the counter |
| data_o | output | 8 | Output lane values |
| data_oe | output | 8 | Per-lane drive enable (0 = high impedance) |
| ceo_n | output | 1 | Active-low cascade enable toward the next part |

## Verification
The bench builds two parts with `DEPTH` = 4 and `TC_BYTE` = 3. Each part gets its own four-byte image, and the two are chained through the cascade pin. With an image this short, the terminal count and the handoff are reached within 4 steps in parallel mode and 32 steps in serial mode. That allows the whole 64-bit merged serial stream to be compared bit by bit against both images. Both strap polarities and both output modes are covered, with the straps changed only under reset.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int LANES = 8;

    typedef enum logic {
        OUT_SERIAL   = 1'b0,
        OUT_PARALLEL = 1'b1
    } out_mode_e;

    // Decode the shared pin into a reset request under the polarity strap.
    function automatic logic reset_from_pin(input logic pol_high, input logic pin);
        return pol_high ? pin : !pin;
    endfunction

endpackage

// File: rtl/cfg_rom_array.sv
module cfg_rom_array #(
    parameter int          DEPTH = 16,
    parameter logic [8*DEPTH-1:0] IMAGE = '0,
    localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    rd_byte
);
    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = IMAGE[8*i +: 8];
    end

    always_comb begin
        rd_byte = '0;
        if (int'(addr) < DEPTH) rd_byte = cells[addr];
    end
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
    parameter int CNT_W  = 8,
    parameter int TC_SER = 127,
    parameter int TC_PAR = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             busy,
    input  logic             par,
    output logic [CNT_W-1:0] cnt,
    output logic             past_tc
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t       st_d, st_q;
    logic [CNT_W-1:0] tc_lim;

    assign tc_lim  = par ? CNT_W'(TC_PAR) : CNT_W'(TC_SER);
    assign past_tc = st_q.cnt > tc_lim;
    assign cnt     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (rst || !ce) begin
            st_d.cnt = '0;
        end else if (!past_tc && !busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1 step on an enabled, unstalled edge
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (ce && !past_tc && !busy) |=> (cnt == $past(cnt) + 1'b1));
    // R5 deselect clears the counter
    a_r5_ce_clear: assert property (@(posedge clk) disable iff (rst)
        (!ce) |=> (cnt == '0));
    // R7 stall freezes the counter
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (ce && busy) |=> $stable(cnt));
    // R10 no wrap once past terminal count
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (ce && past_tc) |=> $stable(cnt));
endmodule

// File: rtl/cfg_out_drive.sv
module cfg_out_drive
    import cfg_stream_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             live,
    input  out_mode_e        mode,
    input  logic [7:0]       cur_byte,
    input  logic [2:0]       bit_idx,
    output logic [LANES-1:0] data_o,
    output logic [LANES-1:0] data_oe
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i == 0) begin : g_lane0
            assign data_o[i]  = live ? ((mode == OUT_PARALLEL) ? cur_byte[0]
                                                               : cur_byte[bit_idx]) : 1'b0;
            assign data_oe[i] = live;
        end else begin : g_laneN
            assign data_o[i]  = (live && mode == OUT_PARALLEL) ? cur_byte[i] : 1'b0;
            assign data_oe[i] = live && (mode == OUT_PARALLEL);
        end
    end

    // R8 serial mode keeps upper lanes released
    a_r8_serial_lanes: assert property (@(posedge clk) disable iff (rst)
        (mode == OUT_SERIAL) |-> (data_oe[LANES-1:1] == '0));
    // R9 parallel mode drives all lanes together
    a_r9_lanes_together: assert property (@(posedge clk) disable iff (rst)
        (mode == OUT_PARALLEL) |-> (data_oe == '0 || data_oe == '1));
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom
    import cfg_stream_pkg::*;
#(
    parameter int                 DEPTH   = 16,
    parameter int                 TC_BYTE = DEPTH - 1,
    parameter logic [8*DEPTH-1:0] IMAGE   = '0
) (
    input  logic       clk,
    input  logic       ce_n,
    input  logic       rst_oe,
    input  logic       pol_rst_high,
    input  logic       par_mode,
    input  logic       busy,
    output logic [7:0] data_o,
    output logic [7:0] data_oe,
    output logic       ceo_n
);
    localparam int TC_SER = TC_BYTE * 8 + 7;
    localparam int CNT_W  = $clog2(TC_SER + 2);
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             rst_act;
    logic             ce_act;
    logic [CNT_W-1:0] cnt;
    logic             past_tc;
    logic [AW-1:0]    byte_addr;
    logic [7:0]       cur_byte;
    logic [2:0]       bit_idx;
    out_mode_e        mode;

    assign rst_act = reset_from_pin(pol_rst_high, rst_oe);
    assign ce_act  = !ce_n;
    assign mode    = par_mode ? OUT_PARALLEL : OUT_SERIAL;

    cfg_addr_ctr #(
        .CNT_W  (CNT_W),
        .TC_SER (TC_SER),
        .TC_PAR (TC_BYTE)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst_act),
        .ce      (ce_act),
        .busy    (busy),
        .par     (par_mode),
        .cnt     (cnt),
        .past_tc (past_tc)
    );

    // Serial mode: three low counter bits select the bit, MSB first.
    assign byte_addr = (mode == OUT_PARALLEL) ? AW'(cnt) : AW'(cnt >> 3);
    assign bit_idx   = 3'd7 - cnt[2:0];

    cfg_rom_array #(
        .DEPTH (DEPTH),
        .IMAGE (IMAGE)
    ) u_rom (
        .addr    (byte_addr),
        .rd_byte (cur_byte)
    );

    cfg_out_drive u_drv (
        .clk      (clk),
        .rst      (rst_act),
        .live     (ce_act && !rst_act && !past_tc),
        .mode     (mode),
        .cur_byte (cur_byte),
        .bit_idx  (bit_idx),
        .data_o   (data_o),
        .data_oe  (data_oe)
    );

    assign ceo_n = !(ce_act && !rst_act && past_tc);

    // R6 cascade low means lanes released and part selected
    a_r6_handoff: assert property (@(posedge clk) disable iff (rst_act)
        (!ceo_n) |-> (data_oe == '0 && !ce_n));
    // R2 deselected part drives nothing and holds cascade high
    a_r2_deselect_float: assert property (@(posedge clk) disable iff (rst_act)
        ce_n |-> (data_oe == '0 && ceo_n));
endmodule

// File: tb/tb_cfg_stream_rom.sv
`timescale 1ns/1ps
module tb_cfg_stream_rom;
    localparam logic [31:0] IMG_A = 32'hA53C0F96;
    localparam logic [31:0] IMG_B = 32'h1234C3E1;

    logic clk = 1'b0;
    logic ce_n = 1'b0, pin = 1'b0, pol = 1'b0, par = 1'b1, busy = 1'b0;
    logic [7:0] d0, oe0, d1, oe1;
    logic ceo0, ceo1;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_stream_rom #(.DEPTH(4), .TC_BYTE(3), .IMAGE(IMG_A)) dut (
        .clk(clk), .ce_n(ce_n), .rst_oe(pin), .pol_rst_high(pol), .par_mode(par),
        .busy(busy), .data_o(d0), .data_oe(oe0), .ceo_n(ceo0));

    cfg_stream_rom #(.DEPTH(4), .TC_BYTE(3), .IMAGE(IMG_B)) dut_b (
        .clk(clk), .ce_n(ceo0), .rst_oe(pin), .pol_rst_high(pol), .par_mode(par),
        .busy(busy), .data_o(d1), .data_oe(oe1), .ceo_n(ceo1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] byte_of(input logic [31:0] img, input int k);
        return img[8*k +: 8];
    endfunction

    // Reset under the given straps, then release with the part selected.
    task automatic restart(input logic pol_v, input logic par_v);
        pol = pol_v; par = par_v; busy = 1'b0; ce_n = 1'b0;
        pin = pol_v;
        tick(); tick();
        pin = !pol_v;
        #1;
    endtask

    task automatic t_reset_state();
        tick();
        chk("R4 lanes off in reset", oe0, 8'h00);
        chk("R6 cascade high in reset", ceo0, 1'b1);
        chk("R3 active-low reset keeps chain quiet", oe1, 8'h00);
    endtask

    task automatic t_parallel();
        restart(1'b0, 1'b1);
        chk("R9 byte 0 all lanes", oe0, 8'hFF);
        chk("R9 byte 0 value", d0, byte_of(IMG_A, 0));
        for (int k = 1; k < 4; k++) begin
            tick();
            chk("R1 parallel step", d0, byte_of(IMG_A, k));
        end
        tick();
        chk("R10 released past terminal", oe0, 8'h00);
        chk("R6 cascade low past terminal", ceo0, 1'b0);
        chk("R11 next part byte 0", {oe1, d1}, {8'hFF, byte_of(IMG_B, 0)});
        tick(); tick();
        chk("R10 no wrap", oe0, 8'h00);
        chk("R11 next part byte 2", d1, byte_of(IMG_B, 2));
        pin = 1'b0; #1;
        chk("R6 cascade high on reset", ceo0, 1'b1);
        chk("R2 reset floats lanes", oe0 | oe1, 8'h00);
    endtask

    task automatic t_ceo_ce();
        restart(1'b0, 1'b1);
        repeat (4) tick();
        chk("R6 cascade low before deselect", ceo0, 1'b0);
        ce_n = 1'b1; #1;
        chk("R6 cascade high on deselect", ceo0, 1'b1);
        ce_n = 1'b0;
    endtask

    task automatic t_busy();
        restart(1'b0, 1'b1);
        tick();
        chk("R1 step to byte 1", d0, byte_of(IMG_A, 1));
        busy = 1'b1;
        tick(); tick();
        chk("R7 held under stall", d0, byte_of(IMG_A, 1));
        chk("R7 lanes still driven", oe0, 8'hFF);
        busy = 1'b0;
        tick();
        chk("R7 resumes after stall", d0, byte_of(IMG_A, 2));
    endtask

    task automatic t_ce();
        restart(1'b0, 1'b1);
        tick(); tick();
        ce_n = 1'b1; #1;
        chk("R5 deselect floats at once", oe0, 8'h00);
        tick();
        ce_n = 1'b0; #1;
        chk("R5 counter cleared by deselect", {oe0, d0}, {8'hFF, byte_of(IMG_A, 0)});
    endtask

    task automatic t_polarity();
        restart(1'b1, 1'b1);
        chk("R3 low pin runs when strap high", {oe0, d0}, {8'hFF, byte_of(IMG_A, 0)});
        tick();
        pin = 1'b1; #1;
        chk("R3 high pin is reset when strap high", oe0, 8'h00);
        tick();
        pin = 1'b0; #1;
        chk("R4 restart from byte 0", d0, byte_of(IMG_A, 0));
    endtask

    task automatic t_serial();
        logic [31:0] img;
        logic exp_bit, got;
        int bad_lanes = 0, bad_bits = 0, bad_overlap = 0;
        restart(1'b0, 1'b0);
        for (int k = 0; k < 64; k++) begin
            img = (k < 32) ? IMG_A : IMG_B;
            exp_bit = img[8*((k % 32) / 8) + 7 - (k % 8)];
            got = oe0[0] ? d0[0] : d1[0];
            if ((oe0[7:1] | oe1[7:1]) != 7'd0) bad_lanes++;
            if ((oe0[0] ^ oe1[0]) !== 1'b1 || got !== exp_bit) bad_bits++;
            if (k >= 32 && oe0 != 8'h00) bad_overlap++;
            tick();
        end
        chk("R8 upper lanes released in serial", bad_lanes, 0);
        chk("R8 serial MSB-first merged stream", bad_bits, 0);
        chk("R11 first part floats after handoff", bad_overlap, 0);
        chk("R10 chain ends released", oe0 | oe1, 8'h00);
        chk("R6 last part cascade low", ceo1, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_parallel();
        t_ceo_ce();
        t_busy();
        t_ce();
        t_polarity();
        t_serial();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule